// File: doc/BRIEF.md
# Bus-Scheduled Converter Sequencer with Two-Wire Slave Port

This block sits between a single-channel converter core and a two-wire I2C bus on which it only ever acts as a slave. It runs the converter through a fixed loop: convert, sleep, then serve one bus transaction. The bus traffic decides when the next conversion starts. The SCL and SDA lines are oversampled in the system clock domain. The only drive onto the bus is an enable for an open-drain pull-down on SDA.

Toward the core, the block gives a one-cycle start strobe and a rate-select bit (low for 60 Hz, high for 30 Hz). It takes back a done strobe together with a 16-bit result. The result is held in the block for as long as it sleeps.

A master reads the result with the device address, or writes one configuration byte. A second address, usable only with a write, lets several devices on one bus be restarted together. While a conversion is running, every request is refused. A STOP after an acknowledged transaction starts the next conversion. Reading out all 16 result bits also starts it, without waiting for a STOP.

Top module: `adc_i2c_seq`

## Requirements
- R1: After reset the rate bit `conv_mode30_o` is 0 (60 Hz), SDA is released, and exactly one start strobe is issued without any bus activity.
- R2: `conv_start_o` is high for exactly one clock. It is never raised between a start strobe and the matching `conv_done_i`.
- R3: When the device address is received while a conversion is running, the block leaves SDA released in the acknowledge slot (NACK). A following STOP starts no conversion.
- R4: When idle, address byte 0010100 followed by R/W = 1 is acknowledged by pulling SDA low. The block then returns the 16-bit result MSB first in two bytes, with a master acknowledge between them. SDA changes only while SCL is low.
- R5: With R/W = 0, after the acknowledge, one data byte is accepted and acknowledged. The last bit received (bit 0) sets `conv_mode30_o`: 1 gives 30 Hz, 0 gives 60 Hz.
- R6: The falling SCL edge that ends the 16th result bit starts a conversion before any STOP. The STOP that follows starts no second conversion.
- R7: A STOP after an acknowledged write starts a conversion.
- R8: A repeated START acts as a START. A write, then a repeated START, then a read is served in one transaction. The conversion that follows uses the rate just written.
- R9: When idle, address 1110111 with R/W = 0 is acknowledged. An optional data byte updates the rate. The STOP starts a conversion, and the rate is left unchanged if no data byte was sent.
- R10: Any other address, and 1110111 with R/W = 1, gets a NACK. SDA stays released and the following STOP starts no conversion.
- R11: A result is returned unchanged after any length of sleep.
- R12: If the master answers NACK after the first result byte, SDA stays released for the rest of the transaction. The following STOP starts a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pd_o | output | 1 | Pull-down enable for the open-drain SDA driver |
| conv_start_o | output | 1 | One-cycle conversion start strobe |
| conv_mode30_o | output | 1 | Rate select: 1 = 30 Hz, 0 = 60 Hz |
| conv_done_i | input | 1 | Conversion finished strobe |
| conv_result_i | input | 16 | Conversion result, valid with `conv_done_i` |

## Verification
Several properties are checked on every cycle. The start strobe is a single pulse and never overlaps a running conversion. SDA moves only while the synchronized SCL is low. No acknowledge is held while a conversion runs. The pull-down stays off in the idle and ignore states. The rate bit changes only at the end of a data byte being received.

Other behaviour is visible only through whole transactions, so the bench's scenarios cover it. These are: the exact acknowledge answer to each address class, the bit order of the result, whether a STOP starts a conversion, the repeated-START write-then-read, and the rate in force when each conversion starts.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [3:0] {
      B_IDLE,
      B_ADDR,
      B_AACK,
      B_AHOLD,
      B_WR,
      B_WACK,
      B_WHOLD,
      B_RD,
      B_RACK,
      B_RGO,
      B_IGNORE
   } bus_st_e;
endpackage

// File: rtl/adc_line_sync.sv
module adc_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic [STAGES-1:0] scl_chain;
   logic [STAGES-1:0] sda_chain;
   logic              scl_q;
   logic              sda_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("adc_line_sync: STAGES must be at least 2");
      end
      if (STAGES == 2) begin : g_two
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_chain <= '1;
               sda_chain <= '1;
            end else begin
               scl_chain <= {scl_chain[0], scl_i};
               sda_chain <= {sda_chain[0], sda_i};
            end
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_chain <= '1;
               sda_chain <= '1;
            end else begin
               scl_chain <= {scl_chain[STAGES-2:0], scl_i};
               sda_chain <= {sda_chain[STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_chain[STAGES-1];
         sda_q <= sda_chain[STAGES-1];
      end
   end

   assign scl_o      = scl_chain[STAGES-1];
   assign sda_o      = sda_chain[STAGES-1];
   assign scl_rise_o = scl_o & ~scl_q;
   assign scl_fall_o = ~scl_o & scl_q;
   assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
   assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/adc_conv_track.sv
module adc_conv_track #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              done_i,
   input  logic [DATA_W-1:0] result_i,
   output logic              start_o,
   output logic              busy_o,
   output logic [DATA_W-1:0] result_o
);
   logic              kick_q;
   logic              busy_q;
   logic              start_q;
   logic [DATA_W-1:0] res_q;
   logic              fire;

   assign fire = (kick_q | req_i) & ~busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kick_q  <= 1'b1;
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         res_q   <= '0;
      end else begin
         start_q <= fire;
         if (fire) begin
            kick_q <= 1'b0;
            busy_q <= 1'b1;
         end else if (busy_q && done_i) begin
            busy_q <= 1'b0;
            res_q  <= result_i;
         end
      end
   end

   assign start_o  = start_q;
   assign busy_o   = busy_q;
   assign result_o = res_q;

   p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);
   p_no_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> !$past(busy_q));
endmodule

// File: rtl/adc_bus_fsm.sv
module adc_bus_fsm
   import adc_seq_pkg::*;
#(
   parameter int         DATA_W    = 16,
   parameter logic [6:0] DEV_ADDR  = 7'b0010100,
   parameter logic [6:0] SYNC_ADDR = 7'b1110111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] result_i,
   output logic              sda_pd_o,
   output logic              mode30_o,
   output logic              conv_req_o
);
   localparam int NBYTES = DATA_W / 8;
   localparam int BI_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;

   generate
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_width
         $error("adc_bus_fsm: DATA_W must be a positive multiple of 8");
      end
   endgenerate

   bus_st_e           st_q;
   logic [2:0]        bitcnt_q;
   logic [BI_W-1:0]   byte_q;
   logic [6:0]        sh_q;
   logic [DATA_W-1:0] rsr_q;
   logic              rd_q;
   logic              txn_ok_q;
   logic              pd_q;
   logic              mode_q;
   logic              req_q;
   logic              hit_dev;
   logic              hit_sync;
   logic              accept;
   logic              last_byte;

   always_comb begin
      hit_dev   = (sh_q == DEV_ADDR);
      hit_sync  = (sh_q == SYNC_ADDR) && !sda_s;
      accept    = (hit_dev || hit_sync) && !busy_i;
      last_byte = (byte_q == BI_W'(NBYTES - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= B_IDLE;
         bitcnt_q <= '0;
         byte_q   <= '0;
         sh_q     <= '0;
         rsr_q    <= '0;
         rd_q     <= 1'b0;
         txn_ok_q <= 1'b0;
         pd_q     <= 1'b0;
         mode_q   <= 1'b0;
         req_q    <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (start_det) begin
            st_q     <= B_ADDR;
            bitcnt_q <= '0;
            pd_q     <= 1'b0;
         end else if (stop_det) begin
            st_q     <= B_IDLE;
            pd_q     <= 1'b0;
            req_q    <= txn_ok_q && !busy_i;
            txn_ok_q <= 1'b0;
         end else begin
            unique case (st_q)
               B_ADDR: if (scl_rise) begin
                  if (bitcnt_q == 3'd7) begin
                     if (accept) begin
                        st_q     <= B_AACK;
                        rd_q     <= sda_s;
                        txn_ok_q <= 1'b1;
                        if (sda_s) rsr_q <= result_i;
                     end else begin
                        st_q     <= B_IGNORE;
                        txn_ok_q <= 1'b0;
                     end
                  end else begin
                     sh_q     <= {sh_q[5:0], sda_s};
                     bitcnt_q <= bitcnt_q + 3'd1;
                  end
               end
               B_AACK: if (scl_fall) begin
                  pd_q <= 1'b1;
                  st_q <= B_AHOLD;
               end
               B_AHOLD: if (scl_fall) begin
                  bitcnt_q <= '0;
                  byte_q   <= '0;
                  if (rd_q) begin
                     pd_q <= ~rsr_q[DATA_W-1];
                     st_q <= B_RD;
                  end else begin
                     pd_q <= 1'b0;
                     st_q <= B_WR;
                  end
               end
               B_WR: if (scl_rise) begin
                  if (bitcnt_q == 3'd7) begin
                     mode_q <= sda_s;
                     st_q   <= B_WACK;
                  end else begin
                     bitcnt_q <= bitcnt_q + 3'd1;
                  end
               end
               B_WACK: if (scl_fall) begin
                  pd_q <= 1'b1;
                  st_q <= B_WHOLD;
               end
               B_WHOLD: if (scl_fall) begin
                  pd_q <= 1'b0;
                  st_q <= B_IGNORE;
               end
               B_RD: if (scl_fall) begin
                  if (bitcnt_q == 3'd7) begin
                     pd_q <= 1'b0;
                     if (last_byte) begin
                        req_q    <= !busy_i;
                        txn_ok_q <= 1'b0;
                        st_q     <= B_IGNORE;
                     end else begin
                        st_q <= B_RACK;
                     end
                  end else begin
                     bitcnt_q <= bitcnt_q + 3'd1;
                     rsr_q    <= rsr_q << 1;
                     pd_q     <= ~rsr_q[DATA_W-2];
                  end
               end
               B_RACK: if (scl_rise) begin
                  st_q <= sda_s ? B_IGNORE : B_RGO;
               end
               B_RGO: if (scl_fall) begin
                  rsr_q    <= rsr_q << 1;
                  pd_q     <= ~rsr_q[DATA_W-2];
                  bitcnt_q <= '0;
                  byte_q   <= byte_q + BI_W'(1);
                  st_q     <= B_RD;
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pd_o   = pd_q;
   assign mode30_o   = mode_q;
   assign conv_req_o = req_q;

   p_pd_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pd_q) |-> !$past(scl_s));
   p_ack_idle_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == B_AHOLD) |-> !busy_i);
   p_mode_on_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mode_q) |-> $past(st_q == B_WR));
   p_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == B_IDLE || st_q == B_IGNORE) |-> !pd_q);
endmodule

// File: rtl/adc_i2c_seq.sv
module adc_i2c_seq #(
   parameter int         DATA_W      = 16,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] DEV_ADDR    = 7'b0010100,
   parameter logic [6:0] SYNC_ADDR   = 7'b1110111
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pd_o,
   output logic              conv_start_o,
   output logic              conv_mode30_o,
   input  logic              conv_done_i,
   input  logic [DATA_W-1:0] conv_result_i
);
   logic              scl_s;
   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_det;
   logic              stop_det;
   logic              busy;
   logic              conv_req;
   logic [DATA_W-1:0] result;

   adc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_o      (scl_s),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_det),
      .stop_o     (stop_det)
   );

   adc_bus_fsm #(
      .DATA_W    (DATA_W),
      .DEV_ADDR  (DEV_ADDR),
      .SYNC_ADDR (SYNC_ADDR)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_s      (scl_s),
      .sda_s      (sda_s),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_det  (start_det),
      .stop_det   (stop_det),
      .busy_i     (busy),
      .result_i   (result),
      .sda_pd_o   (sda_pd_o),
      .mode30_o   (conv_mode30_o),
      .conv_req_o (conv_req)
   );

   adc_conv_track #(.DATA_W(DATA_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_i    (conv_req),
      .done_i   (conv_done_i),
      .result_i (conv_result_i),
      .start_o  (conv_start_o),
      .busy_o   (busy),
      .result_o (result)
   );
endmodule

// File: tb/test_adc_i2c_seq.sv
module test_adc_i2c_seq;
   localparam int Q    = 8;
   localparam int CONV = 600;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_pd;
   logic        conv_start;
   logic        conv_mode30;
   logic        conv_done = 1'b0;
   logic [15:0] conv_result = '0;
   wire         sda_line = sda_m & ~sda_pd;

   int          n_checks = 0;
   int          n_fail = 0;
   int          mon_err = 0;
   int          starts = 0;
   int          remaining = 0;
   bit          busy_m = 1'b0;
   bit          prev_start = 1'b0;
   bit          mode_at_start = 1'b0;
   bit          finished = 1'b0;
   logic [15:0] last_result = '0;

   always #5 clk = ~clk;

   adc_i2c_seq i_adc_i2c_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl_m),
      .sda_i         (sda_line),
      .sda_pd_o      (sda_pd),
      .conv_start_o  (conv_start),
      .conv_mode30_o (conv_mode30),
      .conv_done_i   (conv_done),
      .conv_result_i (conv_result)
   );

   function automatic logic [15:0] conv_value(int n);
      return 16'hA5C3 ^ 16'(n * 16'h1357);
   endfunction

   // behavioural converter model, compared on every clock (R2)
   always @(negedge clk) begin
      conv_done = 1'b0;
      if (rst_n) begin
         if (conv_start) begin
            if (busy_m || prev_start) mon_err++;
            busy_m        = 1'b1;
            remaining     = CONV;
            starts++;
            mode_at_start = conv_mode30;
         end else if (busy_m) begin
            remaining--;
            if (remaining == 0) begin
               busy_m      = 1'b0;
               last_result = conv_value(starts);
               conv_result = last_result;
               conv_done   = 1'b1;
            end
         end
         prev_start = conv_start;
      end
   end

   task automatic check(bit ok, string req, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic clocks(int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; clocks(Q);
      scl_m = 1'b1; clocks(Q);
      sda_m = 1'b0; clocks(Q);
      scl_m = 1'b0; clocks(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; clocks(Q);
      scl_m = 1'b1; clocks(Q);
      sda_m = 1'b1; clocks(Q);
   endtask

   task automatic send_bit(bit b, output bit smp);
      sda_m = b; clocks(Q);
      scl_m = 1'b1; clocks(Q);
      @(negedge clk) smp = sda_line;
      clocks(Q);
      scl_m = 1'b0; clocks(Q);
   endtask

   task automatic send_byte(logic [7:0] b, output bit ack);
      bit s;
      for (int i = 7; i >= 0; i--) send_bit(b[i], s);
      send_bit(1'b1, ack);
   endtask

   task automatic recv_byte(bit m_ack, output logic [7:0] d);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         send_bit(1'b1, s);
         d[i] = s;
      end
      send_bit(!m_ack, s);
   endtask

   task automatic wait_idle();
      while (busy_m) @(posedge clk);
      clocks(20);
   endtask

   initial begin
      bit          ack;
      bit          s;
      logic [7:0]  hi;
      logic [7:0]  lo;
      int          c0;
      clocks(4);
      rst_n = 1'b1;
      clocks(20);
      // R1 reset state
      check(starts == 1, "R1 start after reset", starts, 1);
      check(conv_mode30 == 1'b0, "R1 reset rate", conv_mode30, 0);
      check(sda_pd == 1'b0, "R1 SDA released", sda_pd, 0);

      // R3 address while converting
      bus_start();
      send_byte({7'b0010100, 1'b1}, ack);
      check(ack == 1'b1, "R3 NACK while busy", ack, 1);
      bus_stop(); clocks(50);
      check(starts == 1, "R3 no start after refused", starts, 1);

      // R4 / R6 plain read
      wait_idle();
      bus_start();
      send_byte({7'b0010100, 1'b1}, ack);
      check(ack == 1'b0, "R4 ACK when idle", ack, 0);
      recv_byte(1'b1, hi);
      recv_byte(1'b0, lo);
      check({hi, lo} == last_result, "R4 result MSB first", {hi, lo}, last_result);
      check(starts == 2, "R6 start after 16th bit", starts, 2);
      check(mode_at_start == 1'b0, "R6 rate at start", mode_at_start, 0);
      bus_stop(); clocks(50);
      check(starts == 2, "R6 STOP adds no start", starts, 2);

      // R5 / R8 write, repeated START, read
      wait_idle();
      bus_start();
      send_byte({7'b0010100, 1'b0}, ack);
      check(ack == 1'b0, "R5 write address ACK", ack, 0);
      send_byte(8'h01, ack);
      check(ack == 1'b0, "R5 data byte ACK", ack, 0);
      check(conv_mode30 == 1'b1, "R5 30 Hz selected", conv_mode30, 1);
      bus_start();
      send_byte({7'b0010100, 1'b1}, ack);
      check(ack == 1'b0, "R8 read after repeated START", ack, 0);
      recv_byte(1'b1, hi);
      recv_byte(1'b0, lo);
      check({hi, lo} == last_result, "R8 result", {hi, lo}, last_result);
      check(starts == 3 && mode_at_start == 1'b1, "R8 new rate used", mode_at_start, 1);
      bus_stop(); clocks(50);

      // R9 sync address, no byte then with byte
      wait_idle();
      bus_start();
      send_byte({7'b1110111, 1'b0}, ack);
      check(ack == 1'b0, "R9 sync address ACK", ack, 0);
      bus_stop(); clocks(50);
      check(starts == 4, "R9 STOP starts conversion", starts, 4);
      check(mode_at_start == 1'b1, "R9 rate unchanged", mode_at_start, 1);
      wait_idle();
      bus_start();
      send_byte({7'b1110111, 1'b0}, ack);
      send_byte(8'hFE, ack);
      check(ack == 1'b0, "R9 sync data ACK", ack, 0);
      bus_stop(); clocks(50);
      check(starts == 5 && mode_at_start == 1'b0, "R9 rate updated to 60 Hz", mode_at_start, 0);

      // R10 mismatches, R7 write then STOP
      wait_idle();
      c0 = starts;
      bus_start();
      send_byte({7'b1010101, 1'b1}, ack);
      check(ack == 1'b1, "R10 foreign address NACK", ack, 1);
      bus_stop(); clocks(50);
      bus_start();
      send_byte({7'b1110111, 1'b1}, ack);
      check(ack == 1'b1, "R10 sync read NACK", ack, 1);
      bus_stop(); clocks(50);
      check(starts == c0, "R10 no start after mismatch", starts, c0);
      bus_start();
      send_byte({7'b0010100, 1'b0}, ack);
      bus_stop(); clocks(50);
      check(starts == c0 + 1, "R7 STOP after write starts", starts, c0 + 1);

      // R11 hold over long sleep, R12 master NACK mid-read
      wait_idle();
      clocks(3000);
      bus_start();
      send_byte({7'b0010100, 1'b1}, ack);
      recv_byte(1'b0, hi);
      check(hi == last_result[15:8], "R11 held result", hi, last_result[15:8]);
      send_bit(1'b1, s);
      check(s == 1'b1, "R12 SDA released after NACK", s, 1);
      c0 = starts;
      bus_stop(); clocks(50);
      check(starts == c0 + 1, "R12 STOP starts conversion", starts, c0 + 1);

      check(mon_err == 0, "R2 strobe vs busy", mon_err, 0);
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      clocks(150000);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule